// File: doc/BRIEF.md
# Edge-Pulse Level-Shift Transmitter

This block carries an on/off command for a high-side switch across a boundary without ever sending the command as a steady level. The active-low command is first synchronized to the local clock. Each change of the command then launches one narrow pulse of fixed length. A transition towards "on" fires a pulse on the set path, and a transition towards "off" fires a pulse on the reset path. On the receiving side a set/reset latch turns these pulses back into a held gate-enable level. Because the pulses are short, the link draws energy only around command changes.

A supply-good flag for the floating high-side supply gates the rebuilt output. While the flag is low, the gate-enable is held off. The latch keeps its content during that time, so the stored command shows again once the supply recovers. The pulse length, counted in clock cycles, is a parameter. Both pulse paths are brought out as ports so that they can be observed.

Top module: `edge_pulse_link`

## Requirements
- R1: `cmd_n` passes through a two-stage synchronizer before edge detection. A change of `cmd_n` that is set up before clock edge k produces its pulse in the cycle that follows clock edge k+2.
- R2: A high-to-low change of `cmd_n` (low means switch on) produces a pulse on `set_pulse`. A low-to-high change produces a pulse on `reset_pulse`.
- R3: Each pulse stays high for exactly `PULSE_CYCLES` clock cycles (parameter, at least 1) and then returns low, even while the command level is held.
- R4: The rebuilt gate level becomes 1 one cycle after a `set_pulse` cycle and 0 one cycle after a `reset_pulse` cycle. Between pulses it holds its value.
- R5: At most one of the two pulses is high in any cycle. A new edge during a running pulse ends that pulse at once and starts the full-length pulse for the new edge in the next cycle.
- R6: While `hs_supply_ok` is 0, `gate_en` is 0 whatever the latch holds. The latch still follows its pulses, and `gate_en` shows the latch content again in the same cycle that `hs_supply_ok` returns to 1.
- R7: While `rst_n` is 0 at a clock edge, the latch is cleared, the pulses are cleared and the synchronizer is set to the "off" level. After reset is released with `cmd_n` held high, no pulse is produced and `gate_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_n | input | 1 | Raw high-side command, active low (0 = on), asynchronous |
| hs_supply_ok | input | 1 | High-side floating supply above its undervoltage threshold |
| set_pulse | output | 1 | Turn-on pulse, `PULSE_CYCLES` cycles long |
| reset_pulse | output | 1 | Turn-off pulse, `PULSE_CYCLES` cycles long |
| gate_en | output | 1 | Rebuilt high-side gate enable |

## Verification
The command is driven with long, isolated on and off levels. These show that each direction reaches its own path after the synchronizer latency, and that the latch keeps the level once the pulse has ended. An on command issued while the supply flag is low separates masking from clearing: the gate must appear only when the flag returns. An off edge followed one cycle later by an on edge shows that a pulse is cut short and replaced rather than queued or merged. A second instance with a one-cycle pulse, together with a reset applied while the gate is on, pins down the parameterized width and the idle state after reset.

// File: rtl/epl_pkg.sv
// Shared types for the edge-pulse link.
package epl_pkg;
    // Which pulse path is currently being driven.
    typedef enum logic [1:0] {
        PK_IDLE = 2'b00,
        PK_ON   = 2'b01,
        PK_OFF  = 2'b10
    } pulse_kind_t;
endpackage

// File: rtl/epl_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2. Every stage resets to RST_VAL.
module epl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/epl_oneshot.sv
// Edge detector and one-shot generator. A falling edge of the synchronized
// active-low command starts an on pulse and a rising edge starts an off
// pulse. Each pulse lasts PULSE_CYCLES cycles. A new edge during a pulse
// replaces the running pulse.
// Assumes: PULSE_CYCLES >= 1 and the input is already synchronous.
module epl_oneshot
    import epl_pkg::*;
#(
    parameter int PULSE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n_sync,
    output logic on_pulse,
    output logic off_pulse
);
    localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    logic        prev_n;
    logic        fall_evt;
    logic        rise_evt;
    pulse_kind_t kind_q;
    logic [CW-1:0] left_q;

    // Keep last synchronized level; reset value means "off".
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= cmd_n_sync;
    end

    // Edge events from the level history.
    always_comb begin
        fall_evt = prev_n & ~cmd_n_sync;
        rise_evt = ~prev_n & cmd_n_sync;
    end

    // Start, restart or expire the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= PK_IDLE;
            left_q <= '0;
        end else if (fall_evt) begin
            kind_q <= PK_ON;
            left_q <= LOAD;
        end else if (rise_evt) begin
            kind_q <= PK_OFF;
            left_q <= LOAD;
        end else if (kind_q != PK_IDLE) begin
            if (left_q == '0) kind_q <= PK_IDLE;
            else              left_q <= left_q - 1'b1;
        end
    end

    // Decode the pulse kind onto the two paths.
    always_comb begin
        on_pulse  = (kind_q == PK_ON);
        off_pulse = (kind_q == PK_OFF);
    end
endmodule

// File: rtl/epl_far_latch.sv
// Receiving-side set/reset latch with supply masking. A set pulse stores
// "on" and a reset pulse stores "off". Reset has priority. The output is
// masked while the floating supply is not good; the stored value is kept.
// Assumes: pulses are synchronous to clk.
module epl_far_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    input  logic supply_ok,
    output logic gate_hold,
    output logic gate_out
);
    // Hold the command between pulses, reset first.
    always_ff @(posedge clk) begin
        if (!rst_n)      gate_hold <= 1'b0;
        else if (clr_in) gate_hold <= 1'b0;
        else if (set_in) gate_hold <= 1'b1;
    end

    // Undervoltage forces the gate off.
    always_comb gate_out = gate_hold & supply_ok;
endmodule

// File: rtl/edge_pulse_link.sv
// Top: pulsed level-shift link. The command is synchronized and turned into
// per-edge set/reset pulses, and the pulses drive a far-side latch.
// Assumes: cmd_n asynchronous, hs_supply_ok synchronous to clk.
module edge_pulse_link #(
    parameter int PULSE_CYCLES = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic hs_supply_ok,
    output logic set_pulse,
    output logic reset_pulse,
    output logic gate_en
);
    logic cmd_n_sync;
    logic gate_hold;

    epl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmd_n),
        .q_sync  (cmd_n_sync)
    );

    epl_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_shot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n_sync (cmd_n_sync),
        .on_pulse   (set_pulse),
        .off_pulse  (reset_pulse)
    );

    epl_far_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_in    (set_pulse),
        .clr_in    (reset_pulse),
        .supply_ok (hs_supply_ok),
        .gate_hold (gate_hold),
        .gate_out  (gate_en)
    );
endmodule

// File: rtl/epl_checker.sv
// Property checker for edge_pulse_link, bound to every instance.
module epl_checker #(
    parameter int PULSE_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic hs_supply_ok,
    input logic set_pulse,
    input logic reset_pulse,
    input logic gate_en,
    input logic gate_hold
);
    logic [15:0] on_run;
    logic [15:0] off_run;

    // Count how long each pulse path has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_run  <= '0;
            off_run <= '0;
        end else begin
            on_run  <= set_pulse   ? on_run + 1'b1  : '0;
            off_run <= reset_pulse ? off_run + 1'b1 : '0;
        end
    end

    a_r3_on_width: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> (on_run < 16'(PULSE_CYCLES)));
    a_r3_off_width: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (off_run < 16'(PULSE_CYCLES)));
    a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_pulse, reset_pulse}));
    a_r4_set_on: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> gate_hold);
    a_r4_clr_off: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !gate_hold);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pulse && !reset_pulse) |=> $stable(gate_hold));
    a_r6_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_supply_ok |-> !gate_en);
endmodule

bind edge_pulse_link epl_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (.*);

// File: tb/sim_edge_pulse_link.sv
module sim_edge_pulse_link;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_n = 1'b1;
    logic ok = 1'b1;
    logic set0, rst0, gate0, set1, rst1, gate1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    edge_pulse_link #(.PULSE_CYCLES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .hs_supply_ok(ok),
        .set_pulse(set0), .reset_pulse(rst0), .gate_en(gate0));
    edge_pulse_link #(.PULSE_CYCLES(1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .hs_supply_ok(ok),
        .set_pulse(set1), .reset_pulse(rst1), .gate_en(gate1));

    // Row: {cmd_n, ok, exp set, exp reset, exp gate}. The expectation is
    // checked at the negedge before the row's inputs are driven.
    localparam int NV = 30;
    localparam logic [4:0] VEC [NV] = '{
        5'b11000, 5'b01000, 5'b01000, 5'b01000, 5'b01100,
        5'b01101, 5'b01101, 5'b01001, 5'b11001, 5'b11001,
        5'b11001, 5'b11011, 5'b11010, 5'b11010, 5'b11000,
        5'b00000, 5'b00000, 5'b00000, 5'b00100, 5'b00100,
        5'b01100, 5'b01001, 5'b11001, 5'b01001, 5'b01001,
        5'b01011, 5'b01100, 5'b01101, 5'b01101, 5'b01001
    };

    task automatic chk(input string tag, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input string what,
                           input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w_on0, w_on1, w_off0, w_off1;
        string tag;
        // R7: state during reset.
        repeat (4) @(negedge clk);
        chk("R7", "set in reset", set0, 1'b0);
        chk("R7", "reset in reset", rst0, 1'b0);
        chk("R7", "gate in reset", gate0, 1'b0);
        rst_n = 1'b1;

        // Table walk: R1 latency, R2 paths, R3 width, R4 hold, R6, R5.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i < 15)      tag = "R1_R2_R3_R4";
            else if (i < 22) tag = "R6";
            else             tag = "R5";
            chk(tag, $sformatf("row %0d set", i), set0, VEC[i][2]);
            chk(tag, $sformatf("row %0d reset", i), rst0, VEC[i][1]);
            chk(tag, $sformatf("row %0d gate", i), gate0, VEC[i][0]);
            cmd_n = VEC[i][4];
            ok    = VEC[i][3];
        end

        // R3: width set by the parameter, 3 on u0 and 1 on u1.
        @(negedge clk);
        cmd_n = 1'b1;
        w_off0 = 0; w_off1 = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rst0) w_off0++;
            if (rst1) w_off1++;
        end
        chk_int("R3", "off width u0", w_off0, 3);
        chk_int("R3", "off width u1", w_off1, 1);
        chk("R4", "gate off after off pulse", gate1, 1'b0);
        cmd_n = 1'b0;
        w_on0 = 0; w_on1 = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (set0) w_on0++;
            if (set1) w_on1++;
        end
        chk_int("R3", "on width u0", w_on0, 3);
        chk_int("R3", "on width u1", w_on1, 1);
        chk("R4", "gate on held u1", gate1, 1'b1);

        // R7: reset while gate on, then idle with command held off.
        cmd_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", "gate cleared by reset", gate0, 1'b0);
        rst_n = 1'b1;
        w_on0 = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (set0 || rst0 || gate0) w_on0++;
        end
        chk_int("R7", "activity after reset", w_on0, 0);
        finish_run();
    end
endmodule